// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequences that move an 8-bit processor core into its reset handler or into one of its two interrupt handlers. The core presents its current program counter, stack pointer and status byte together with a one-cycle `boundary` strobe just before each instruction fetch. If an interrupt is to be taken, the block saves the return state on the stack in page one, fetches the handler address from the matching vector pair over a simple memory port, and hands the new program counter, stack pointer and status back to the core with a one-cycle `done` pulse.

Interrupt requests arrive on two paths. A non-maskable request is latched until the next instruction boundary consumes it. The maskable sources form a small bit mask: each bit is set and cleared by its own strobes and stays asserted until cleared. The exception is a designated one-shot bit, which is dropped at the boundary that consumes it. A halt request puts the block in a halted state in which no interrupt is entered. Reset is the only way out of that state.

After reset is released, the block fetches the reset vector on its own, loads the program counter from it, and leaves the status byte with only the interrupt-disable flag set.

Top module: `irqseq_top`

## Requirements
- R1: When reset is released, the block reads 0xFFFC and then 0xFFFD. It then loads the program counter with {byte@0xFFFD, byte@0xFFFC}, sets the status to 0x04, leaves the stack pointer at 0x00, clears `halted`, and pulses `done` with `entryKind` = 0.
- R2: At a boundary where a non-maskable request is pending and the block is not halted, a non-maskable entry starts. This happens whatever the value of `iFlagPrev` and whatever maskable bits are pending. The entry reads 0xFFFA (low byte) and then 0xFFFB (high byte), loads the program counter with {high, low}, and returns the status exactly as it was presented. `entryKind` is 1.
- R3: A maskable entry starts only when no non-maskable request is pending, at least one source bit is pending, `iFlagPrev` is 0 and the block is not halted. It reads 0xFFFE and then 0xFFFF, loads the program counter with {high, low}, and returns the presented status with bit 2 (interrupt disable) set. `entryKind` is 2.
- R4: Every entry makes three stack writes, in this order: PC[15:8] to 0x0100+S, PC[7:0] to 0x0100+S-1, and the status with bit 4 cleared and bit 5 set to 0x0100+S-2. S wraps within 8 bits, and the returned stack pointer is S-3 modulo 256.
- R5: An interrupt entry keeps `busy` high for exactly 7 cycles after the boundary cycle. The first two of those cycles make no memory access. `done` is a single-cycle pulse in the eighth cycle after the boundary, and the new state is valid on the outputs from that cycle.
- R6: A `haltReq` pulse sets `halted`. While halted, a boundary starts no entry and makes no memory access.
- R7: A maskable source bit is set by its `irqSet` bit and stays pending until its `irqClr` bit is asserted. When both strobes are asserted in the same cycle, the clear wins. A bit that is still pending is entered again at a later boundary.
- R8: At a boundary where any request is pending, the non-maskable request and one-shot source bit 0 are discarded, whether or not an entry results: masked, halted, or lost to a non-maskable entry. A request that arrives in that same cycle is kept.
- R9: A `boundary` strobe that arrives while a sequence is running is ignored. A request raised during the sequence is still served at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; release starts the reset sequence |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| pcIn | input | 16 | Core program counter (return address) |
| spIn | input | 8 | Core stack pointer |
| statusIn | input | 8 | Core status byte |
| iFlagPrev | input | 1 | Interrupt-disable flag latched before the previous instruction |
| irqSet | input | SRC_W | Per-source set strobes for maskable requests |
| irqClr | input | SRC_W | Per-source clear strobes for maskable requests |
| nmiReq | input | 1 | Non-maskable request strobe |
| haltReq | input | 1 | Puts the block in the halted state |
| memRdata | input | 8 | Read data, valid in the same cycle as the address |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Stack write enable |
| memRe | output | 1 | Vector read enable |
| memWdata | output | 8 | Stack write data |
| pcOut | output | 16 | Program counter after entry |
| spOut | output | 8 | Stack pointer after entry |
| statusOut | output | 8 | Status byte after entry |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the new state is loaded |
| entryKind | output | 2 | Kind of the last entry: 0 reset, 1 non-maskable, 2 maskable |
| halted | output | 1 | Block is halted |

## Verification
The bench targets the requests that must be lost: a one-shot bit masked at a boundary, a one-shot bit pending beside a non-maskable request, and any request while halted. A design that kept them would start a spurious entry later, and a design that dropped level sources would miss the re-entry expected after a non-maskable entry. Stack-pointer wrap from 0x01 through 0xFF catches a push address computed at more than 8 bits. A status byte presented with bit 4 set catches a pushed status that forgets to clear it. Same-cycle set and clear, a boundary raised mid-sequence, and a masked boundary all catch wrong priority between competing strobes, which would show up as an entry that should not start or a sequence that restarts.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RLO, ST_RHI, ST_W1, ST_W2,
    ST_PH, ST_PL, ST_PP, ST_VLO, ST_VHI
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_RST = 2'd0,
    KIND_NMI = 2'd1,
    KIND_IRQ = 2'd2
  } entry_kind_e;

  typedef struct packed {
    logic        capture;
    logic        push;
    logic [1:0]  pushSel;
    logic        rdLo;
    logic        rdHi;
    logic        fromReset;
    entry_kind_e kind;
  } seq_strobe_t;

  function automatic logic [15:0] vecBase(entry_kind_e k);
    case (k)
      KIND_NMI: vecBase = 16'hFFFA;
      KIND_IRQ: vecBase = 16'hFFFE;
      default:  vecBase = 16'hFFFC;
    endcase
  endfunction

endpackage

// File: rtl/irqseq_pend.sv
module irqseq_pend #(
  parameter int SRC_W       = 4,
  parameter int ONESHOT_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] irqSet,
  input  logic [SRC_W-1:0] irqClr,
  input  logic             nmiReq,
  input  logic             consume,
  output logic [SRC_W-1:0] irqPend,
  output logic             nmiPend
);

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    logic dropBit;
    if (i == ONESHOT_BIT) begin : g_once
      assign dropBit = consume;
    end else begin : g_level
      assign dropBit = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqPend[i] <= 1'b0;
      else       irqPend[i] <= ((irqPend[i] & ~dropBit) | irqSet[i]) & ~irqClr[i];
    end

    // R7: a clear strobe removes the bit on the next cycle, even against a set
    a_r7_clr_wins: assert property (@(posedge clk) disable iff (!rstN)
      irqClr[i] |=> !irqPend[i]);
    // R7: a set without clear makes the bit pending
    a_r7_set_holds: assert property (@(posedge clk) disable iff (!rstN)
      (irqSet[i] && !irqClr[i]) |=> irqPend[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPend <= 1'b0;
    else       nmiPend <= (nmiPend & ~consume) | nmiReq;
  end

  // R8: a request arriving during consumption survives
  a_r8_new_nmi_kept: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> nmiPend);

endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        nmiPend,
  input  logic        irqAny,
  input  logic        iFlagPrev,
  input  logic        haltReq,
  output seq_strobe_t strb,
  output logic        consume,
  output logic        busy,
  output logic        done,
  output logic [1:0]  entryKind,
  output logic        halted
);

  seq_state_e  state, stateNext;
  entry_kind_e kindReg;
  logic        doneReg;
  logic        atBound, takeNmi, takeIrq;

  assign atBound = (state == ST_IDLE) && boundary;
  assign takeNmi = atBound && nmiPend && !halted;
  assign takeIrq = atBound && !nmiPend && irqAny && !iFlagPrev && !halted;
  assign consume = atBound && (nmiPend || irqAny);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (takeNmi || takeIrq) stateNext = ST_W1;
      ST_RLO:  stateNext = ST_RHI;
      ST_RHI:  stateNext = ST_IDLE;
      ST_W1:   stateNext = ST_W2;
      ST_W2:   stateNext = ST_PH;
      ST_PH:   stateNext = ST_PL;
      ST_PL:   stateNext = ST_PP;
      ST_PP:   stateNext = ST_VLO;
      ST_VLO:  stateNext = ST_VHI;
      ST_VHI:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RLO;
      kindReg <= KIND_RST;
      doneReg <= 1'b0;
      halted  <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_VHI) || (state == ST_RHI);
      halted  <= halted | haltReq;
      if (takeNmi)      kindReg <= KIND_NMI;
      else if (takeIrq) kindReg <= KIND_IRQ;
    end
  end

  always_comb begin
    strb           = '0;
    strb.kind      = kindReg;
    strb.capture   = takeNmi || takeIrq;
    strb.push      = (state == ST_PH) || (state == ST_PL) || (state == ST_PP);
    strb.pushSel   = (state == ST_PH) ? 2'd0 : (state == ST_PL) ? 2'd1 : 2'd2;
    strb.rdLo      = (state == ST_VLO) || (state == ST_RLO);
    strb.rdHi      = (state == ST_VHI) || (state == ST_RHI);
    strb.fromReset = (state == ST_RLO) || (state == ST_RHI);
  end

  assign busy      = (state != ST_IDLE);
  assign done      = doneReg;
  assign entryKind = kindReg;

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: halted block never starts an entry
  a_r6_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (atBound && halted) |=> !busy);
  // R3: masked maskable request without NMI starts nothing
  a_r3_masked: assert property (@(posedge clk) disable iff (!rstN)
    (atBound && !nmiPend && iFlagPrev) |=> !busy);
  // R2: pending NMI wins at a boundary
  a_r2_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (atBound && nmiPend && !halted) |=> (busy && entryKind == KIND_NMI));

endmodule

// File: rtl/irqseq_dpath.sv
module irqseq_dpath
  import irqseq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strb,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  input  logic [7:0]  statusIn,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [7:0]  memWdata,
  output logic [15:0] pcOut,
  output logic [7:0]  spOut,
  output logic [7:0]  statusOut
);

  localparam logic [7:0] RESET_STATUS = 8'(1 << FLAG_I);

  logic [15:0] pcR;
  logic [7:0]  spR, stR, vecLo;
  logic [15:0] vecAddr;
  logic [7:0]  pushedStatus;

  assign vecAddr      = vecBase(strb.kind) + {15'd0, strb.rdHi};
  assign pushedStatus = (stR & ~8'(1 << FLAG_B)) | 8'(1 << FLAG_U);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR   <= '0;
      spR   <= '0;
      stR   <= '0;
      vecLo <= '0;
    end else begin
      if (strb.capture) begin
        pcR <= pcIn;
        spR <= spIn;
        stR <= statusIn;
      end
      if (strb.push) spR <= spR - 8'd1;
      if (strb.rdLo) vecLo <= memRdata;
      if (strb.rdHi) begin
        pcR <= {memRdata, vecLo};
        if (strb.fromReset)             stR <= RESET_STATUS;
        else if (strb.kind == KIND_IRQ) stR <= stR | RESET_STATUS;
      end
    end
  end

  always_comb begin
    memAddr = '0;
    if (strb.push)                  memAddr = {STACK_PAGE, spR};
    else if (strb.rdLo || strb.rdHi) memAddr = vecAddr;
  end

  assign memWe = strb.push;
  assign memRe = strb.rdLo || strb.rdHi;

  always_comb begin
    case (strb.pushSel)
      2'd0:    memWdata = pcR[15:8];
      2'd1:    memWdata = pcR[7:0];
      default: memWdata = pushedStatus;
    endcase
  end

  assign pcOut     = pcR;
  assign spOut     = spR;
  assign statusOut = stR;

  // R4: each push moves the stack pointer down by one, wrapping in 8 bits
  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (spOut == 8'($past(spOut) - 8'd1)));
  // R5: reads and writes never share a cycle
  a_r5_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  // R2: the high vector byte comes from the address after the low one
  a_r2_vec_hi_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdHi |-> (memAddr == $past(memAddr) + 16'd1));

endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
  import irqseq_pkg::*;
#(
  parameter int         SRC_W       = 4,
  parameter int         ONESHOT_BIT = 0,
  parameter logic [7:0] STACK_PAGE  = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic [15:0]      pcIn,
  input  logic [7:0]       spIn,
  input  logic [7:0]       statusIn,
  input  logic             iFlagPrev,
  input  logic [SRC_W-1:0] irqSet,
  input  logic [SRC_W-1:0] irqClr,
  input  logic             nmiReq,
  input  logic             haltReq,
  input  logic [7:0]       memRdata,
  output logic [15:0]      memAddr,
  output logic             memWe,
  output logic             memRe,
  output logic [7:0]       memWdata,
  output logic [15:0]      pcOut,
  output logic [7:0]       spOut,
  output logic [7:0]       statusOut,
  output logic             busy,
  output logic             done,
  output logic [1:0]       entryKind,
  output logic             halted
);

  logic [SRC_W-1:0] irqPend;
  logic             nmiPend;
  logic             consume;
  seq_strobe_t      strb;

  irqseq_pend #(.SRC_W(SRC_W), .ONESHOT_BIT(ONESHOT_BIT)) u_pend (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqClr(irqClr),
    .nmiReq(nmiReq), .consume(consume), .irqPend(irqPend), .nmiPend(nmiPend)
  );

  irqseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiPend(nmiPend),
    .irqAny(|irqPend), .iFlagPrev(iFlagPrev), .haltReq(haltReq),
    .strb(strb), .consume(consume), .busy(busy), .done(done),
    .entryKind(entryKind), .halted(halted)
  );

  irqseq_dpath #(.STACK_PAGE(STACK_PAGE)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .spIn(spIn),
    .statusIn(statusIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWe(memWe), .memRe(memRe), .memWdata(memWdata), .pcOut(pcOut),
    .spOut(spOut), .statusOut(statusOut)
  );

endmodule

// File: tb/irqseq_top_test.sv
module irqseq_top_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  spIn = '0, statusIn = '0;
  logic        iFlagPrev = 1'b0;
  logic [3:0]  irqSet = '0, irqClr = '0;
  logic        nmiReq = 1'b0, haltReq = 1'b0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr, pcOut;
  logic        memWe, memRe, busy, done, halted;
  logic [7:0]  memWdata, spOut, statusOut;
  logic [1:0]  entryKind;

  int errors = 0;
  int checks = 0;

  int          accN, busyN, firstAcc, doneAt;
  logic [15:0] accAddr [8];
  logic        accWe   [8];
  logic [7:0]  accData [8];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] rom(logic [15:0] a);
    case (a)
      16'hFFFA: rom = 8'hA0;
      16'hFFFB: rom = 8'hC1;
      16'hFFFC: rom = 8'h00;
      16'hFFFD: rom = 8'h80;
      16'hFFFE: rom = 8'h55;
      16'hFFFF: rom = 8'hE7;
      default:  rom = 8'h00;
    endcase
  endfunction
  assign memRdata = rom(memAddr);

  irqseq_top uut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .pcIn(pcIn), .spIn(spIn),
    .statusIn(statusIn), .iFlagPrev(iFlagPrev), .irqSet(irqSet),
    .irqClr(irqClr), .nmiReq(nmiReq), .haltReq(haltReq), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .pcOut(pcOut), .spOut(spOut), .statusOut(statusOut), .busy(busy),
    .done(done), .entryKind(entryKind), .halted(halted)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Follow a sequence from the current negedge until done; optional mid-run boundary.
  task automatic track(input int midAt);
    accN = 0; busyN = 0; firstAcc = -1; doneAt = -1;
    for (int k = 1; k <= 40; k++) begin
      if (busy) busyN++;
      if ((memWe || memRe) && accN < 8) begin
        if (firstAcc < 0) firstAcc = k;
        accAddr[accN] = memAddr; accWe[accN] = memWe; accData[accN] = memWdata;
        accN++;
      end
      if (done) begin doneAt = k; break; end
      if (k == midAt) boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
    end
  endtask

  task automatic pulseBoundary();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic expectIdle(input string tag);
    logic seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (busy || memWe || memRe || done) seen = 1'b1;
      @(negedge clk);
    end
    check(tag, {31'd0, seen}, 32'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    track(0);
    check("R1 read count", accN, 2);
    check("R1 first read", accAddr[0], 16'hFFFC);
    check("R1 second read", accAddr[1], 16'hFFFD);
    check("R1 pc", pcOut, 16'h8000);
    check("R1 status", statusOut, 8'h04);
    check("R1 sp", spOut, 8'h00);
    check("R1 kind", entryKind, 2'd0);
    check("R1 halted clear", halted, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_nmi_priority();
    irqSet = 4'b0100; nmiReq = 1'b1;
    @(negedge clk);
    irqSet = '0; nmiReq = 1'b0;
    pcIn = 16'h1234; spIn = 8'hFD; statusIn = 8'hD1; iFlagPrev = 1'b1;
    pulseBoundary();
    track(0);
    check("R5 busy cycles", busyN, 7);
    check("R5 first access cycle", firstAcc, 3);
    check("R5 done cycle", doneAt, 8);
    check("R4 access count", accN, 5);
    check("R4 push hi addr", accAddr[0], 16'h01FD);
    check("R4 push hi data", accData[0], 8'h12);
    check("R4 push lo addr", accAddr[1], 16'h01FC);
    check("R4 push lo data", accData[1], 8'h34);
    check("R4 push status addr", accAddr[2], 16'h01FB);
    check("R4 push status data", accData[2], 8'hE1);
    check("R2 vec lo addr", accAddr[3], 16'hFFFA);
    check("R2 vec hi addr", accAddr[4], 16'hFFFB);
    check("R2 pc", pcOut, 16'hC1A0);
    check("R2 status kept", statusOut, 8'hD1);
    check("R4 sp", spOut, 8'hFA);
    check("R2 kind", entryKind, 2'd1);
    @(negedge clk);
    check("R5 done one cycle", done, 1'b0);
  endtask

  task automatic t_irq_level_wrap();
    pcIn = 16'hABCD; spIn = 8'h01; statusIn = 8'h00; iFlagPrev = 1'b0;
    pulseBoundary();
    track(0);
    check("R7 level reentry kind", entryKind, 2'd2);
    check("R4 wrap hi addr", accAddr[0], 16'h0101);
    check("R4 wrap lo addr", accAddr[1], 16'h0100);
    check("R4 wrap status addr", accAddr[2], 16'h01FF);
    check("R4 status data", accData[2], 8'h20);
    check("R3 vec lo addr", accAddr[3], 16'hFFFE);
    check("R3 vec hi addr", accAddr[4], 16'hFFFF);
    check("R3 pc", pcOut, 16'hE755);
    check("R3 status I set", statusOut, 8'h04);
    check("R4 sp wrap", spOut, 8'hFE);
  endtask

  task automatic t_mask_and_clear();
    iFlagPrev = 1'b1;
    pulseBoundary();
    expectIdle("R3 masked no entry");
    irqSet = 4'b1100; irqClr = 4'b1100;
    @(negedge clk);
    irqSet = '0; irqClr = '0;
    iFlagPrev = 1'b0;
    pulseBoundary();
    expectIdle("R7 clear wins no entry");
  endtask

  task automatic t_oneshot();
    irqSet = 4'b0001; iFlagPrev = 1'b1;
    @(negedge clk);
    irqSet = '0;
    pulseBoundary();
    iFlagPrev = 1'b0;
    expectIdle("R8 masked oneshot no entry");
    pulseBoundary();
    expectIdle("R8 masked oneshot dropped");
    irqSet = 4'b0011; nmiReq = 1'b1;
    @(negedge clk);
    irqSet = '0; nmiReq = 1'b0;
    pulseBoundary();
    track(0);
    check("R8 nmi taken with oneshot", entryKind, 2'd1);
    pulseBoundary();
    track(0);
    check("R8 level bit1 survives nmi", entryKind, 2'd2);
    irqClr = 4'b0010;
    @(negedge clk);
    irqClr = '0;
    pulseBoundary();
    expectIdle("R8 oneshot lost to nmi");
  endtask

  task automatic t_busy_ignore();
    nmiReq = 1'b1;
    @(negedge clk);
    nmiReq = 1'b0;
    pulseBoundary();
    nmiReq = 1'b1;
    track(3);
    nmiReq = 1'b0;
    check("R9 first run length", doneAt, 8);
    @(negedge clk);
    expectIdle("R9 mid boundary ignored");
    pulseBoundary();
    track(0);
    check("R9 request kept kind", entryKind, 2'd1);
    check("R9 request kept done", doneAt, 8);
  endtask

  task automatic t_halt();
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    check("R6 halted set", halted, 1'b1);
    nmiReq = 1'b1; irqSet = 4'b0100; iFlagPrev = 1'b0;
    @(negedge clk);
    nmiReq = 1'b0; irqSet = '0;
    pulseBoundary();
    expectIdle("R6 nmi blocked");
    pulseBoundary();
    expectIdle("R6 irq blocked");
    doReset();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    t_nmi_priority();
    t_irq_level_wrap();
    t_mask_and_clear();
    t_oneshot();
    t_busy_ignore();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule